// File: doc/BRIEF.md
# Packed Lane Shuffle Execution Unit

This unit assembles a 128-bit result out of four 32-bit lanes taken from two operands. The two lower result lanes may be picked only from the destination operand. The two upper result lanes may be picked only from the source operand. An 8-bit select immediate holds four 2-bit fields, one per result lane, and each field names the operand lane to copy. Within an operand, lane n occupies bits [32n+31:32n].

Before the result is committed, the unit screens the operation for faults. It checks the control enables, the feature flag, the task-switched flag, the alignment of a memory source, and the real-mode address window. Only the fault with the highest priority is reported, and a faulted operation produces no write. The source can be flagged as an alias of the destination register. In that case the upper lanes are taken from the destination value as it was before the write. The outputs are registered, so a result appears one cycle after the request.

Top module: `lane_shuffle_unit`

## Requirements
- R1: Result lane 0 copies destination lane sel_imm[1:0], and result lane 1 copies destination lane sel_imm[3:2]. A field value n selects bits [32n+31:32n].
- R2: Result lane 2 copies source lane sel_imm[5:4], and result lane 3 copies source lane sel_imm[7:6], with the same field-to-bit mapping as R1.
- R3: With src_alias high, lanes 2 and 3 are picked from dst_opnd, using its value before the write, and src_opnd has no effect on the result.
- R4: out_fault = 1 (invalid opcode) when ctl_emul is 1, when ctl_os_ext is 0, or when feat_packed is 0.
- R5: out_fault = 2 (device not available) when task_sw is 1.
- R6: out_fault = 3 (protection) when src_is_mem is 1 and mem_addr[3:0] is not 0.
- R7: out_fault = 4 (range) when real_mode and src_is_mem are both 1 and mem_addr + 15 > 0xFFFF, that is mem_addr > 0xFFF0.
- R8: When several faults are present at once, code 1 wins over 2, 2 over 3, and 3 over 4. Code 0 means no fault.
- R9: A response with a nonzero fault has out_write = 0 and out_result = 0. A response with no fault has out_write = 1 and carries the shuffled result.
- R10: out_valid rises exactly one cycle after in_valid. Reset and idle cycles hold out_valid, out_write, out_fault and out_result at 0.
- R11: With src_is_mem = 0, mem_addr and real_mode have no effect on the fault code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| dst_opnd | input | 128 | Destination operand, four 32-bit lanes |
| src_opnd | input | 128 | Source operand, four 32-bit lanes |
| sel_imm | input | 8 | Four 2-bit lane-select fields |
| src_alias | input | 1 | Source register is the destination register |
| src_is_mem | input | 1 | Source operand comes from memory |
| mem_addr | input | 32 | Byte address of the memory source |
| real_mode | input | 1 | Real-address mode active |
| ctl_emul | input | 1 | Emulation enable (faults when 1) |
| ctl_os_ext | input | 1 | OS extended-state support (faults when 0) |
| feat_packed | input | 1 | Packed-single feature present (faults when 0) |
| task_sw | input | 1 | Task-switched flag |
| out_valid | output | 1 | Response strobe |
| out_result | output | 128 | Shuffled result, 0 on fault |
| out_write | output | 1 | Commit the result to the destination |
| out_fault | output | 3 | Highest-priority fault code |

## Verification
Several fault conditions can be present in the same request, and all of them compete for the single fault code in the same cycle. The bench provokes this with random control flags and addresses biased toward misaligned and near-limit values. It compares each code with a bench function that applies the priority order independently of the RTL. The aliased-source case is also judged in the same cycle: the bench drives an unrelated src_opnd and checks that the upper lanes still reflect the destination value present before the write.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_UD    = 3'd1,
    FLT_NM    = 3'd2,
    FLT_GP    = 3'd3,
    FLT_RANGE = 3'd4
  } fault_e;
endpackage

// File: rtl/lane_picker.sv
module lane_picker #(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  localparam int SEL_W = $clog2(LANES),
  localparam int DW    = LANE_W * LANES
) (
  input  logic [DW-1:0]          lo_opnd,
  input  logic [DW-1:0]          hi_opnd,
  input  logic [SEL_W*LANES-1:0] sel,
  output logic [DW-1:0]          picked
);
  function automatic logic [LANE_W-1:0] lane_of(input logic [DW-1:0] v,
                                                input logic [SEL_W-1:0] idx);
    return v[idx*LANE_W +: LANE_W];
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SEL_W-1:0] field;
    assign field = sel[g*SEL_W +: SEL_W];
    if (g < LANES/2) begin : g_lo
      assign picked[g*LANE_W +: LANE_W] = lane_of(lo_opnd, field);
    end else begin : g_hi
      assign picked[g*LANE_W +: LANE_W] = lane_of(hi_opnd, field);
    end
  end
endmodule

// File: rtl/fault_screen.sv
module fault_screen #(
  parameter int ADDR_W   = 32,
  parameter int OPND_B   = 16,
  parameter int REAL_TOP = 16'hFFFF,
  localparam int AL_W    = $clog2(OPND_B)
) (
  input  logic              src_is_mem,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              real_mode,
  input  logic              ctl_emul,
  input  logic              ctl_os_ext,
  input  logic              feat_packed,
  input  logic              task_sw,
  output shuf_pkg::fault_e  code,
  output logic              ud_hit,
  output logic              nm_hit,
  output logic              gp_hit,
  output logic              rng_hit
);
  import shuf_pkg::*;

  logic [ADDR_W:0] last_byte;
  assign last_byte = {1'b0, mem_addr} + (ADDR_W+1)'(OPND_B - 1);

  assign ud_hit  = ctl_emul | ~ctl_os_ext | ~feat_packed;
  assign nm_hit  = task_sw;
  assign gp_hit  = src_is_mem & (mem_addr[AL_W-1:0] != '0);
  assign rng_hit = src_is_mem & real_mode & (last_byte > (ADDR_W+1)'(REAL_TOP));

  always_comb begin
    if (ud_hit)       code = FLT_UD;
    else if (nm_hit)  code = FLT_NM;
    else if (gp_hit)  code = FLT_GP;
    else if (rng_hit) code = FLT_RANGE;
    else              code = FLT_NONE;
  end

  always_comb begin
    // R8
    if (ud_hit) ud_first_chk: assert (code == FLT_UD);
    // R11
    if (!src_is_mem) reg_src_chk: assert (code != FLT_GP && code != FLT_RANGE);
  end
endmodule

// File: rtl/lane_shuffle_unit.sv
module lane_shuffle_unit #(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  parameter int ADDR_W = 32,
  localparam int DW    = LANE_W * LANES,
  localparam int SW    = $clog2(LANES) * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DW-1:0]     dst_opnd,
  input  logic [DW-1:0]     src_opnd,
  input  logic [SW-1:0]     sel_imm,
  input  logic              src_alias,
  input  logic              src_is_mem,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              real_mode,
  input  logic              ctl_emul,
  input  logic              ctl_os_ext,
  input  logic              feat_packed,
  input  logic              task_sw,
  output logic              out_valid,
  output logic [DW-1:0]     out_result,
  output logic              out_write,
  output logic [2:0]        out_fault
);
  import shuf_pkg::*;

  logic [DW-1:0] hi_src, picked;
  fault_e        code;
  logic          ud_hit, nm_hit, gp_hit, rng_hit;
  logic          commit_ok;

  // aliased source reads the pre-write destination value
  assign hi_src = src_alias ? dst_opnd : src_opnd;

  lane_picker #(.LANE_W(LANE_W), .LANES(LANES)) u_pick (
    .lo_opnd(dst_opnd), .hi_opnd(hi_src), .sel(sel_imm), .picked(picked)
  );

  fault_screen #(.ADDR_W(ADDR_W), .OPND_B(DW/8)) u_screen (
    .src_is_mem(src_is_mem), .mem_addr(mem_addr), .real_mode(real_mode),
    .ctl_emul(ctl_emul), .ctl_os_ext(ctl_os_ext), .feat_packed(feat_packed),
    .task_sw(task_sw), .code(code), .ud_hit(ud_hit), .nm_hit(nm_hit),
    .gp_hit(gp_hit), .rng_hit(rng_hit)
  );

  assign commit_ok = in_valid & (code == FLT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_write  <= 1'b0;
      out_fault  <= 3'd0;
    end else begin
      out_valid  <= in_valid;
      out_write  <= commit_ok;
      out_result <= commit_ok ? picked : '0;
      out_fault  <= in_valid ? code : FLT_NONE;
    end
  end

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_write && out_fault == 3'd0));
  // R9
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_write == (out_fault == 3'd0)));
  // R9
  quiet_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault != 3'd0) |-> out_result == '0);
  // R5
  nm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nm_hit && !ud_hit) |=> out_fault == 3'd2);
  // R6
  gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gp_hit && !ud_hit && !nm_hit) |=> out_fault == 3'd3);
  // R7
  rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rng_hit && !ud_hit && !nm_hit && !gp_hit) |=> out_fault == 3'd4);
endmodule

// File: tb/lane_shuffle_unit_tb.sv
module lane_shuffle_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] dst_opnd = '0, src_opnd = '0;
  logic [7:0]   sel_imm = '0;
  logic         src_alias = 1'b0, src_is_mem = 1'b0;
  logic [31:0]  mem_addr = '0;
  logic         real_mode = 1'b0, ctl_emul = 1'b0, ctl_os_ext = 1'b1;
  logic         feat_packed = 1'b1, task_sw = 1'b0;
  logic         out_valid, out_write;
  logic [127:0] out_result;
  logic [2:0]   out_fault;
  int           n_chk = 0, n_err = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  lane_shuffle_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_opnd(dst_opnd),
    .src_opnd(src_opnd), .sel_imm(sel_imm), .src_alias(src_alias),
    .src_is_mem(src_is_mem), .mem_addr(mem_addr), .real_mode(real_mode),
    .ctl_emul(ctl_emul), .ctl_os_ext(ctl_os_ext), .feat_packed(feat_packed),
    .task_sw(task_sw), .out_valid(out_valid), .out_result(out_result),
    .out_write(out_write), .out_fault(out_fault)
  );

  function automatic logic [127:0] exp_shuffle(input logic [127:0] lo,
      input logic [127:0] hi, input logic [7:0] s);
    logic [127:0] r;
    for (int i = 0; i < 4; i++) begin
      logic [127:0] from;
      from = (i < 2) ? lo : hi;
      r[32*i +: 32] = 32'(from >> (32 * int'(s[2*i +: 2])));
    end
    return r;
  endfunction

  function automatic logic [2:0] exp_fault();
    if (ctl_emul || !ctl_os_ext || !feat_packed) return 3'd1;
    if (task_sw) return 3'd2;
    if (src_is_mem && mem_addr[3:0] != 4'd0) return 3'd3;
    if (src_is_mem && real_mode && mem_addr > 32'hFFF0) return 3'd4;
    return 3'd0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clean_ctl();
    src_alias = 0; src_is_mem = 0; mem_addr = 0; real_mode = 0;
    ctl_emul = 0; ctl_os_ext = 1; feat_packed = 1; task_sw = 0;
  endtask

  // issue at negedge, inspect one full cycle later (after the capturing edge)
  task automatic run(input string req);
    logic [127:0] e_res;
    logic [2:0]   e_flt;
    e_flt = exp_fault();
    e_res = (e_flt != 0) ? 128'd0
          : exp_shuffle(dst_opnd, src_alias ? dst_opnd : src_opnd, sel_imm);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, {req, "/R10 valid"}, 128'(out_valid), 128'd1);
    check(out_fault === e_flt, {req, " fault"}, 128'(out_fault), 128'(e_flt));
    check(out_write === (e_flt == 0), {req, "/R9 write"}, 128'(out_write),
          128'(e_flt == 0));
    check(out_result === e_res, {req, " result"}, out_result, e_res);
  endtask

  initial begin
    void'($urandom(32'd4711));
    #5;
    check(out_valid === 0 && out_write === 0 && out_fault === 0 && out_result === 0,
          "R10 reset", {out_valid, out_write, out_fault}, 128'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: every select value, random lane data
    for (int s = 0; s < 256; s++) begin
      dst_opnd = {$urandom, $urandom, $urandom, $urandom};
      src_opnd = {$urandom, $urandom, $urandom, $urandom};
      sel_imm = 8'(s);
      run("R1 R2 sweep");
    end
    // R1 R2 directed: distinct lane markers
    dst_opnd = 128'h33333333_22222222_11111111_00000000;
    src_opnd = 128'hDDDDDDDD_CCCCCCCC_BBBBBBBB_AAAAAAAA;
    sel_imm = 8'b00_11_10_01;
    run("R1 R2 directed");

    // R3: aliased source ignores src_opnd
    for (int k = 0; k < 20; k++) begin
      src_alias = 1;
      dst_opnd = {$urandom, $urandom, $urandom, $urandom};
      src_opnd = {$urandom, $urandom, $urandom, $urandom};
      sel_imm = 8'($urandom);
      run("R3 alias");
    end
    clean_ctl();

    // R4 each cause alone
    ctl_emul = 1;     run("R4 emul");     clean_ctl();
    ctl_os_ext = 0;   run("R4 os_ext");   clean_ctl();
    feat_packed = 0;  run("R4 feature");  clean_ctl();
    // R5
    task_sw = 1;      run("R5 task_sw");  clean_ctl();
    // R6
    src_is_mem = 1; mem_addr = 32'h0000_1008; run("R6 misalign"); clean_ctl();
    src_is_mem = 1; mem_addr = 32'h0000_1010; run("R6 aligned ok"); clean_ctl();
    // R7 window edges
    src_is_mem = 1; real_mode = 1; mem_addr = 32'h0000_FFF0; run("R7 last fit");
    mem_addr = 32'h0001_0000; run("R7 past top"); clean_ctl();
    src_is_mem = 1; real_mode = 0; mem_addr = 32'h0001_0000; run("R7 not real");
    clean_ctl();
    // R11 register source ignores address checks
    real_mode = 1; mem_addr = 32'h0012_3457; run("R11 reg src"); clean_ctl();
    // R8 combinations
    ctl_emul = 1; task_sw = 1; src_is_mem = 1; mem_addr = 32'h3; run("R8 all"); clean_ctl();
    task_sw = 1; src_is_mem = 1; mem_addr = 32'h3; run("R8 nm>gp"); clean_ctl();
    src_is_mem = 1; real_mode = 1; mem_addr = 32'h0002_0004; run("R8 gp>rng"); clean_ctl();
    // R8 random mixture
    for (int k = 0; k < 300; k++) begin
      dst_opnd = {$urandom, $urandom, $urandom, $urandom};
      src_opnd = {$urandom, $urandom, $urandom, $urandom};
      sel_imm = 8'($urandom);
      ctl_emul = ($urandom % 6) == 0;
      ctl_os_ext = ($urandom % 6) != 0;
      feat_packed = ($urandom % 6) != 0;
      task_sw = ($urandom % 5) == 0;
      src_is_mem = $urandom % 2;
      real_mode = $urandom % 2;
      src_alias = $urandom % 2;
      mem_addr = ($urandom % 2) ? 32'hFFF0 + ($urandom % 32) : $urandom % 32'h20000;
      run("R8 random");
    end
    clean_ctl();

    // R10 idle after response
    @(negedge clk);
    check(out_valid === 0 && out_write === 0 && out_fault === 0, "R10 idle",
          {out_valid, out_write, out_fault}, 128'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule